// File: doc/BRIEF.md
# Cascadable Line Loading Sequencer

This block sequences the loading of one display line into a row of pixel slots. The row has 128 slots. Each slot holds three 6-bit sub-pixels, so a line covers 384 channels. A direction input picks one of two pins as the start input and the other as the cascade output. The same input also picks the fill order: upward from slot 0, or downward from slot 127.

Loading begins on the rising edge of the start signal on the selected pin. The first pixel can be written in the next cycle. Each accepted pixel word produces a one-hot slot write enable and a 7-bit slot index, which drive a separate storage array. When the last slot has been written, the block drops into standby by itself. In standby it ignores pixel strobes until the next start.

In a chain of chips, each stage's cascade output feeds the next stage's start input, and all other inputs are shared. The cascade pulse is timed so that the next stage sees its start in the same cycle as this stage's final slot. The next stage can then accept a pixel in the very next cycle. Pin tristate drivers are represented by separate output-enable and output-value signals.

Top module: `line_fill_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, no slot write enable is asserted, and neither pin's output value is asserted.
- R2: With `dir_fwd` = 1, pin A is the start input and pin B is the driven cascade output (`pin_b_oe` = 1, `pin_a_oe` = 0). With `dir_fwd` = 0, the roles swap.
- R3: A load starts only on a 0-to-1 transition of the selected start pin, sampled at a clock edge. A pulse one or two cycles wide starts exactly one load. Activity on the pin that is not selected has no effect.
- R4: The cycle right after the edge that samples the start rise is already a load cycle. A pixel strobed in that cycle is written, so the write lands on the second edge counted from the start sample.
- R5: `slot_we` is one-hot with its set bit at `slot_idx`. For a forward load the index runs 0, 1, … 127 in order. For a reverse load it runs 127, 126, … 0. The direction is captured at start.
- R6: The load advances by one slot only in cycles with `pix_valid` high. `slot_data` carries `pix_data` unchanged during a write.
- R7: After slot 128 of the line has been written, `busy` falls and `slot_we` stays 0 for any `pix_valid`, until a new start.
- R8: The cascade output pin is high for exactly one cycle: the cycle in which the final slot of the line is the current slot, reached after the 127th write. It is never asserted on the pin that is not output-enabled.
- R9: A start rise during a load restarts the load from the first slot of the order captured at that start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_fwd | input | 1 | 1: start on pin A, fill upward; 0: start on pin B, fill downward |
| pin_a_in | input | 1 | Sampled level of bidirectional pin A |
| pin_b_in | input | 1 | Sampled level of bidirectional pin B |
| pix_valid | input | 1 | Pixel word strobe |
| pix_data | input | 18 | Three 6-bit sub-pixels of one pixel |
| pin_a_out | output | 1 | Value driven on pin A |
| pin_a_oe | output | 1 | Output enable of pin A |
| pin_b_out | output | 1 | Value driven on pin B |
| pin_b_oe | output | 1 | Output enable of pin B |
| busy | output | 1 | 1 while loading; 0 in standby |
| slot_idx | output | 7 | Index of the current slot |
| slot_we | output | 128 | One-hot slot write enable |
| slot_data | output | 18 | Write data for the enabled slot |

## Verification
The assertions check the following on every cycle:
- the write enable is one-hot and agrees with the slot index;
- no write occurs outside a load;
- the two pin enables are complementary, and a pin is driven only when enabled;
- the cascade pulse lasts one cycle and appears only while a load is active.

The bench scenarios show the behaviour that depends on history:
- the exact upward and downward index sequences under random strobe gaps;
- the two-edge start latency;
- the cascade pulse landing on the final slot;
- standby ignoring strobes;
- restarts in mid-line and start pulses of width two;
- pulses on the pin that is not selected being ignored.

// File: rtl/line_fill_pkg.sv
// Package: shared sizing defaults and the load state type for the line
// loading sequencer. Assumes every user derives index widths from SLOTS.
package line_fill_pkg;
    localparam int unsigned DEF_SLOTS = 128;
    localparam int unsigned DEF_SUB_W = 6;
    localparam int unsigned DEF_SUBS  = 3;

    typedef enum logic {
        FILL_STANDBY = 1'b0,
        FILL_RUN     = 1'b1
    } fill_state_t;
endpackage

// File: rtl/lfs_start_edge.sv
// Module: selects the start pin by direction and reports its rising edge.
// Assumes the pin levels are already synchronous to clk.
module lfs_start_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic dir_fwd,
    input  logic pin_a_in,
    input  logic pin_b_in,
    output logic start_pulse
);
    logic sel_lvl;
    logic sel_q;

    // Purpose: pick the pin that acts as the start input.
    always_comb sel_lvl = dir_fwd ? pin_a_in : pin_b_in;

    // Purpose: remember the previous sampled level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel_lvl;
    end

    // Purpose: a start is a low-to-high step between two samples.
    always_comb start_pulse = sel_lvl & ~sel_q;
endmodule

// File: rtl/lfs_fill_ctrl.sv
// Module: load state machine. Counts accepted pixels, captures the fill
// direction at start, enters standby after the last slot, and raises the
// cascade flag for the single cycle in which the final slot is current.
// Assumes SLOTS >= 2.
module lfs_fill_ctrl
    import line_fill_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_pulse,
    input  logic             dir_fwd,
    input  logic             pix_valid,
    output logic             busy,
    output logic             write_en,
    output logic             fwd_lat,
    output logic [IDX_W-1:0] cnt,
    output logic             casc
);
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(SLOTS - 1);
    localparam logic [IDX_W-1:0] PRE_LAST = IDX_W'(SLOTS - 2);

    fill_state_t state;

    // Purpose: advance the load, restart on start, and time the cascade flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= FILL_STANDBY;
            cnt     <= '0;
            fwd_lat <= 1'b1;
            casc    <= 1'b0;
        end else if (start_pulse) begin
            state   <= FILL_RUN;
            cnt     <= '0;
            fwd_lat <= dir_fwd;
            casc    <= 1'b0;
        end else if (write_en) begin
            casc <= (cnt == PRE_LAST);
            cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) state <= FILL_STANDBY;
        end else begin
            casc <= 1'b0;
        end
    end

    // Purpose: a write happens on any strobe during a load.
    always_comb begin
        busy     = (state == FILL_RUN);
        write_en = busy & pix_valid;
    end
endmodule

// File: rtl/lfs_slot_dec.sv
// Module: turns the load count and the captured direction into a slot index
// and a one-hot write enable. Assumes cnt < SLOTS.
module lfs_slot_dec #(
    parameter int unsigned SLOTS = 128,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input  logic             write_en,
    input  logic             fwd_lat,
    input  logic [IDX_W-1:0] cnt,
    output logic [IDX_W-1:0] slot_idx,
    output logic [SLOTS-1:0] slot_we
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

    // Purpose: map the count to a slot for the chosen fill order.
    always_comb slot_idx = fwd_lat ? cnt : LAST - cnt;

    // Purpose: one compare per slot to form the one-hot enable.
    for (genvar s = 0; s < SLOTS; s++) begin : g_we
        assign slot_we[s] = write_en && (slot_idx == IDX_W'(s));
    end
endmodule

// File: rtl/line_fill_seq.sv
// Module: top of the cascadable line loading sequencer. Routes the start pin
// and the cascade pin by direction and exposes the slot write port.
// Assumes dir_fwd is static during a load and pins are synchronised.
module line_fill_seq
    import line_fill_pkg::*;
#(
    parameter int unsigned SLOTS = DEF_SLOTS,
    parameter int unsigned SUB_W = DEF_SUB_W,
    parameter int unsigned SUBS  = DEF_SUBS,
    localparam int unsigned IDX_W = $clog2(SLOTS),
    localparam int unsigned PIX_W = SUB_W * SUBS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_fwd,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    input  logic             pix_valid,
    input  logic [PIX_W-1:0] pix_data,
    output logic             pin_a_out,
    output logic             pin_a_oe,
    output logic             pin_b_out,
    output logic             pin_b_oe,
    output logic             busy,
    output logic [IDX_W-1:0] slot_idx,
    output logic [SLOTS-1:0] slot_we,
    output logic [PIX_W-1:0] slot_data
);
    logic             start_pulse;
    logic             write_en;
    logic             fwd_lat;
    logic [IDX_W-1:0] cnt;
    logic             casc;

    lfs_start_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_fwd    (dir_fwd),
        .pin_a_in   (pin_a_in),
        .pin_b_in   (pin_b_in),
        .start_pulse(start_pulse)
    );

    lfs_fill_ctrl #(.SLOTS(SLOTS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_pulse(start_pulse),
        .dir_fwd    (dir_fwd),
        .pix_valid  (pix_valid),
        .busy       (busy),
        .write_en   (write_en),
        .fwd_lat    (fwd_lat),
        .cnt        (cnt),
        .casc       (casc)
    );

    lfs_slot_dec #(.SLOTS(SLOTS)) u_dec (
        .write_en(write_en),
        .fwd_lat (fwd_lat),
        .cnt     (cnt),
        .slot_idx(slot_idx),
        .slot_we (slot_we)
    );

    // Purpose: the pin not used as start input drives the cascade flag.
    always_comb begin
        pin_a_oe  = ~dir_fwd;
        pin_b_oe  = dir_fwd;
        pin_a_out = ~dir_fwd & casc;
        pin_b_out = dir_fwd & casc;
        slot_data = pix_data;
    end
endmodule

// File: rtl/line_fill_seq_chk.sv
// Module: property checker for line_fill_seq, attached by bind below.
// Assumes the port widths of the top module it is bound to.
module line_fill_seq_chk #(
    parameter int unsigned SLOTS = 128,
    localparam int unsigned IDX_W = $clog2(SLOTS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic [IDX_W-1:0] slot_idx,
    input logic [SLOTS-1:0] slot_we,
    input logic             pin_a_out,
    input logic             pin_a_oe,
    input logic             pin_b_out,
    input logic             pin_b_oe
);
    logic casc_any;
    always_comb casc_any = pin_a_out | pin_b_out;

    p_we_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_we));

    p_we_at_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we != '0) |-> slot_we[slot_idx]);

    p_no_write_standby_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (slot_we == '0));

    p_oe_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_a_oe != pin_b_oe);

    p_drive_only_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_a_out |-> pin_a_oe) and (pin_b_out |-> pin_b_oe));

    p_casc_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc_any |=> !casc_any);

    p_casc_in_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        casc_any |-> busy);
endmodule

bind line_fill_seq line_fill_seq_chk #(.SLOTS(SLOTS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .slot_idx (slot_idx),
    .slot_we  (slot_we),
    .pin_a_out(pin_a_out),
    .pin_a_oe (pin_a_oe),
    .pin_b_out(pin_b_out),
    .pin_b_oe (pin_b_oe)
);

// File: tb/line_fill_seq_test.sv
`timescale 1ns/1ps
module line_fill_seq_test;
    localparam int N = 128;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_fwd = 1'b1;
    logic         pin_a_in = 1'b0;
    logic         pin_b_in = 1'b0;
    logic         pix_valid = 1'b0;
    logic [17:0]  pix_data = '0;
    logic         pin_a_out, pin_a_oe, pin_b_out, pin_b_oe, busy;
    logic [6:0]   slot_idx;
    logic [N-1:0] slot_we;
    logic [17:0]  slot_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // bench model state, derived from the requirements
    logic e_active = 1'b0;
    int   e_cnt = 0;
    logic e_dir = 1'b1;
    logic e_casc = 1'b0;
    logic e_prev = 1'b0;

    always #2 clk = ~clk;

    line_fill_seq uut (
        .clk(clk), .rst_n(rst_n), .dir_fwd(dir_fwd),
        .pin_a_in(pin_a_in), .pin_b_in(pin_b_in),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
        .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
        .busy(busy), .slot_idx(slot_idx), .slot_we(slot_we),
        .slot_data(slot_data)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // one cycle: drive at the falling edge, compare, then advance the model
    task automatic step(input logic a, input logic b, input logic v, input string tag);
        logic [17:0]  d;
        logic [N-1:0] ew;
        logic         sel;
        int           idx;
        d = 18'($urandom);
        @(negedge clk);
        pin_a_in = a; pin_b_in = b; pix_valid = v; pix_data = d;
        #1;
        if (rst_n) begin
            chk(tag, N'(busy), N'(e_active));
            idx = e_dir ? e_cnt : (N - 1 - e_cnt);
            ew = '0;
            if (e_active && v) ew[idx] = 1'b1;
            chk("R5", slot_we, ew);
            if (e_active && v) begin
                chk("R5", N'(slot_idx), N'(idx));
                chk("R6", N'(slot_data), N'(d));
            end
            chk("R2", N'({pin_a_oe, pin_b_oe}), N'({~dir_fwd, dir_fwd}));
            chk("R8", N'({pin_a_out, pin_b_out}), N'({~dir_fwd & e_casc, dir_fwd & e_casc}));
        end
        @(posedge clk);
        if (!rst_n) begin
            e_active = 1'b0; e_cnt = 0; e_dir = 1'b1; e_casc = 1'b0; e_prev = 1'b0;
        end else begin
            sel = dir_fwd ? a : b;
            if (sel && !e_prev) begin
                e_active = 1'b1; e_cnt = 0; e_dir = dir_fwd; e_casc = 1'b0;
            end else if (e_active && v) begin
                e_casc = (e_cnt == N - 2);
                if (e_cnt == N - 1) e_active = 1'b0;
                e_cnt = (e_cnt + 1) % N;
            end else begin
                e_casc = 1'b0;
            end
            e_prev = sel;
        end
    endtask

    // feed pixels with random strobe gaps until the model reaches standby
    task automatic fill_rest(input string tag);
        while (e_active) step(1'b0, 1'b0, ($urandom % 4) != 0, tag);
    endtask

    task automatic start_on(input logic use_a, input int width);
        for (int w = 0; w < width; w++) step(use_a, ~use_a, 1'b0, "R3");
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b1, "R1");

        // forward load, one-cycle start on pin A
        dir_fwd = 1'b1;
        start_on(1'b1, 1);
        step(1'b0, 1'b0, 1'b1, "R4");
        fill_rest("R5");

        // standby: strobes ignored
        for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b1, "R7");

        // pulse on the unselected pin has no effect
        step(1'b0, 1'b1, 1'b1, "R3");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R3");

        // reverse load, two-cycle start on pin B
        dir_fwd = 1'b0;
        step(1'b0, 1'b1, 1'b0, "R3");
        step(1'b0, 1'b1, 1'b1, "R4");
        fill_rest("R6");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R7");

        // restart in mid-line, forward
        dir_fwd = 1'b1;
        start_on(1'b1, 1);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0, 1'b1, "R6");
        step(1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b1, "R9");
        fill_rest("R9");

        // restart in mid-line, reverse, with two-cycle start
        dir_fwd = 1'b0;
        start_on(1'b0, 1);
        for (int i = 0; i < 70; i++) step(1'b0, 1'b0, ($urandom % 2) == 0, "R6");
        step(1'b0, 1'b1, 1'b0, "R9");
        step(1'b0, 1'b1, 1'b1, "R9");
        fill_rest("R8");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R7");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule